// File: doc/BRIEF.md
# Windowed Temperature Averaging Filter

This block sits behind one core's digital thermal sensor and keeps two readouts of its temperature side by side. The first is the latest raw reading, refreshed whenever the sensor presents a sample with its valid strobe. The second is a mean of the readings taken over a programmable time window. Platform fan control should use the averaged readout, because it smooths out the short spikes that the raw reading shows.

A free-running millisecond tick paces the filter. On each tick the current raw reading is added to an accumulator. When the window's last tick arrives, the sum is divided by the sample count and loaded into the averaged register. The sample count is always a power of two, so the division is a right shift. A one-cycle update strobe goes out with each new average. The window length comes from a 4-bit selection field that is read only at window boundaries. After reset the window is 256 ms.

Top module: `thermal_avg_filter`

## Requirements
- R1: Reset clears the instantaneous and averaged readouts to 0 and holds the update strobe low.
- R2: A cycle with `sample_valid_i` high loads `sample_i` into `inst_o`, and the new value shows on the next cycle.
- R3: The first window after reset lasts 256 ticks, whatever `win_sel_i` holds during that window.
- R4: The window length is 2^`win_sel_i` ticks for selection values 0 to 10. Values 11 to 15 give 1024 ticks.
- R5: `win_sel_i` is read only on the tick that ends a window. A change made in the middle of a window leaves that window's length unchanged and sets the length of the next window.
- R6: Each tick adds the value `inst_o` held before that clock edge. On the closing tick, `avg_o` becomes the sum of the window's samples shifted right by log2 of the window length, with the remainder dropped.
- R7: `avg_upd_o` is high for exactly one cycle, the cycle after each window's closing tick, and at no other time.
- R8: `avg_o` keeps its value between updates, including when new raw samples arrive.
- R9: The accumulator clears at every window boundary. It holds 1024 samples of the maximum value without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_i | input | 8 | Raw temperature reading from the sensor |
| sample_valid_i | input | 1 | Marks `sample_i` as a new reading |
| win_sel_i | input | 4 | Window length selection, as log2 of the tick count |
| ms_tick_i | input | 1 | One-cycle pulse every millisecond |
| inst_o | output | 8 | Latest raw reading |
| avg_o | output | 8 | Average over the last completed window |
| avg_upd_o | output | 1 | One-cycle pulse when `avg_o` is refreshed |

## Verification
The bench changes the selection field in the middle of a window. A filter that reads the field on every tick would close that window early, and the bench would see an early strobe and the wrong average. A sum that does not divide evenly is checked for truncation, so a design that rounds up is caught. Reusing the window's samples without clearing the accumulator would make the next average too large. The longest window, fed 1024 samples of 255, must return exactly 255: too narrow an accumulator would wrap and return a small value. An out-of-range selection must clamp to 1024 ticks rather than be used as a shift amount.

// File: rtl/thermal_avg_pkg.sv
package thermal_avg_pkg;
  // Last count value of a window of 2^sh ticks.
  function automatic logic [31:0] win_last(input logic [3:0] sh);
    return (32'd1 << sh) - 32'd1;
  endfunction

  // Selection clamped to the largest supported shift.
  function automatic logic [3:0] clamp_sel(input logic [3:0] sel,
                                           input int unsigned max_sh);
    return (int'(sel) > int'(max_sh)) ? 4'(max_sh) : sel;
  endfunction
endpackage

// File: rtl/thermal_inst_reg.sv
module thermal_inst_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid_i,
  input  logic [W-1:0] sample_i,
  output logic [W-1:0] inst_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)       inst_o <= '0;
    else if (valid_i) inst_o <= sample_i;
  end

  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> inst_o == $past(sample_i));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(inst_o));
endmodule

// File: rtl/thermal_win_seq.sv
module thermal_win_seq
  import thermal_avg_pkg::*;
#(
  parameter int MAX_SH = 10,
  parameter int DEF_SH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic [3:0] win_sel_i,
  output logic       win_end_o,
  output logic [3:0] shift_o
);
  localparam int CNT_W = MAX_SH + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;

  assign last_cnt  = CNT_W'(win_last(shift_o));
  assign win_end_o = tick_i && (cnt_q == last_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      shift_o <= 4'(DEF_SH);
    end else if (tick_i) begin
      if (win_end_o) begin
        cnt_q   <= '0;
        shift_o <= clamp_sel(win_sel_i, MAX_SH);
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  p_sel_at_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end_o |=> $stable(shift_o));
  p_shift_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(shift_o) <= MAX_SH);
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last_cnt);
endmodule

// File: rtl/thermal_accum.sv
module thermal_accum #(
  parameter int W      = 8,
  parameter int MAX_SH = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         win_end_i,
  input  logic [3:0]   shift_i,
  input  logic [W-1:0] sample_i,
  output logic [W-1:0] avg_o,
  output logic         upd_o
);
  localparam int ACC_W = W + MAX_SH;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  assign sum = {1'b0, acc_q} + (ACC_W+1)'(sample_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      avg_o <= '0;
      upd_o <= 1'b0;
    end else begin
      upd_o <= 1'b0;
      if (tick_i) begin
        if (win_end_i) begin
          avg_o <= W'(sum >> shift_i);
          acc_q <= '0;
          upd_o <= 1'b1;
        end else begin
          acc_q <= sum[ACC_W-1:0];
        end
      end
    end
  end

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |-> !sum[ACC_W]);
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    win_end_i |=> acc_q == '0);
  p_upd_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |-> $past(tick_i));
  p_avg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_o |-> $stable(avg_o));
endmodule

// File: rtl/thermal_avg_filter.sv
module thermal_avg_filter #(
  parameter int SAMPLE_W = 8,
  parameter int MAX_SH   = 10,
  parameter int DEF_SH   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                sample_valid_i,
  input  logic [3:0]          win_sel_i,
  input  logic                ms_tick_i,
  output logic [SAMPLE_W-1:0] inst_o,
  output logic [SAMPLE_W-1:0] avg_o,
  output logic                avg_upd_o
);
  logic       win_end;
  logic [3:0] act_shift;

  thermal_inst_reg #(.W(SAMPLE_W)) u_inst (
    .clk(clk), .rst_n(rst_n), .valid_i(sample_valid_i),
    .sample_i(sample_i), .inst_o(inst_o)
  );

  thermal_win_seq #(.MAX_SH(MAX_SH), .DEF_SH(DEF_SH)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick_i(ms_tick_i), .win_sel_i(win_sel_i),
    .win_end_o(win_end), .shift_o(act_shift)
  );

  thermal_accum #(.W(SAMPLE_W), .MAX_SH(MAX_SH)) u_acc (
    .clk(clk), .rst_n(rst_n), .tick_i(ms_tick_i), .win_end_i(win_end),
    .shift_i(act_shift), .sample_i(inst_o), .avg_o(avg_o), .upd_o(avg_upd_o)
  );

  p_upd_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> avg_upd_o);
endmodule

// File: tb/thermal_avg_filter_bench.sv
module thermal_avg_filter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] sample = '0;
  logic       valid = 1'b0;
  logic [3:0] sel = 4'd8;
  logic       tick = 1'b0;
  logic [7:0] inst, avg;
  logic       upd;
  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  thermal_avg_filter u_thermal_avg_filter (
    .clk(clk), .rst_n(rst_n), .sample_i(sample), .sample_valid_i(valid),
    .win_sel_i(sel), .ms_tick_i(tick), .inst_o(inst), .avg_o(avg),
    .avg_upd_o(upd)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put_sample(input logic [7:0] v);
    @(negedge clk) begin valid = 1'b1; sample = v; end
    @(negedge clk) valid = 1'b0;
  endtask

  // One tick; returns the strobe seen in the following cycle.
  task automatic one_tick(output logic u);
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    u = upd;
  endtask

  // n ticks; counts strobes among the first n-1 and reports the last.
  task automatic run_ticks(input int n, output int early, output logic last_u);
    logic u;
    early = 0;
    last_u = 1'b0;
    for (int i = 0; i < n; i++) begin
      one_tick(u);
      if (i < n - 1) early += int'(u);
      else last_u = u;
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 inst", int'(inst), 0);
    check("R1 avg", int'(avg), 0);
    check("R1 upd", int'(upd), 0);
  endtask

  task automatic t_capture;
    put_sample(8'd50);
    check("R2 capture", int'(inst), 50);
  endtask

  task automatic t_default_window;
    int early; logic lu;
    sel = 4'd2;  // must not shorten the first window
    run_ticks(256, early, lu);
    check("R3 no early strobe", early, 0);
    check("R3 strobe at 256", int'(lu), 1);
    check("R3 avg", int'(avg), 50);
    @(negedge clk);
    check("R7 one-cycle strobe", int'(upd), 0);
  endtask

  task automatic t_mid_change;
    logic u;
    put_sample(8'd10); one_tick(u);
    put_sample(8'd20); one_tick(u);
    sel = 4'd0;  // takes effect only after this window
    put_sample(8'd30); one_tick(u);
    check("R5 no strobe mid-window", int'(u), 0);
    check("R8 avg held", int'(avg), 50);
    put_sample(8'd41); one_tick(u);
    check("R5 strobe after 4", int'(u), 1);
    check("R6 R9 truncated avg", int'(avg), 25);
  endtask

  task automatic t_single;
    logic u;
    put_sample(8'd77); one_tick(u);
    check("R4 window 1 strobe", int'(u), 1);
    check("R4 window 1 avg", int'(avg), 77);
  endtask

  task automatic t_clamp_max;
    logic u; int early; logic lu;
    sel = 4'd15;
    put_sample(8'd200); one_tick(u);
    check("R4 avg 200", int'(avg), 200);
    put_sample(8'd255);
    run_ticks(1023, early, lu);
    check("R4 no strobe before 1024", early + int'(lu), 0);
    check("R8 avg held long window", int'(avg), 200);
    one_tick(u);
    check("R4 strobe at 1024", int'(u), 1);
    check("R9 full-scale avg", int'(avg), 255);
  endtask

  task automatic t_hold;
    put_sample(8'd3);
    repeat (3) @(negedge clk);
    check("R2 inst updated", int'(inst), 3);
    check("R8 avg unchanged", int'(avg), 255);
    check("R7 no strobe without tick", int'(upd), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_capture();
    t_default_window();
    t_mid_change();
    t_single();
    t_clamp_max();
    t_hold();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule